// File: doc/BRIEF.md
# Analog Bias Power-Up Sequencer

This block brings up the reference and bias circuits of a mixed-signal chip in a fixed order once a start request arrives. It drives one enable or select output for each controlled circuit: the mid-rail reference, with its fast-start, ramp-code and divider-select controls; the reference buffer; the master bias; the start-up bias, with its enable and source select; the low-dropout regulator, with its fast-reference select and start-up bias; and the video buffer. It first brings everything up in a fast-start configuration. It then holds two timed settle periods, one after the regulator is enabled and one after the reference is enabled. Finally it moves the reference and regulator to their normal-operation settings and enables the video buffer with the gain and Q-boost values taken from its inputs.

The settle periods are set in milliseconds through parameters. They are converted to clock cycles with a clock-rate parameter in kHz, so a bench can use a low rate to get short waits. A synchronous software reset returns the block to idle from any state, with every controlled output at zero. Once the sequence completes, the done flag holds until the next reset.

States: `ST_IDLE`, `ST_CLEAR` (outputs to defaults), `ST_FAST` (reference fast-start, start-up bias, ramp code), `ST_LDO_PREP` (regulator fast reference and start-up bias), `ST_LDO_ON` (regulator enable, load first wait), `ST_LDO_WAIT`, `ST_BIAS_ON` (master bias, reference buffer, fast divider), `ST_REF_ON` (reference enable, load second wait), `ST_REF_WAIT`, `ST_LDO_NORM`, `ST_REF_NORM`, `ST_VB_CFG` (gain and Q-boost applied), `ST_VB_ON`, `ST_DONE`. Transitions:
- `ST_IDLE` goes to `ST_CLEAR` on start.
- Each step state moves to the next state after one cycle.
- Each wait state moves on after its timer reaches zero.
- `ST_DONE` holds.
- Any state goes to `ST_IDLE` on software reset.

Top module: `bias_powerup_seq`

## Requirements
- R1: After `rst_n` is low, or after a cycle with `sw_rst_i` high, every controlled output (including gain and Q-boost) is 0, and `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse sampled in idle raises `busy_o` at the next clock edge. The first step outputs appear two edges after that sampling edge.
- R3: `mref_fast_o`, `sbias_ena_o` and `sbias_src_o` rise together, with `mref_ramp_o` = 2'b01 at that moment.
- R4: `ldo_fref_o` and `ldo_sbias_o` rise together one cycle after the fast-start step, and `ldo_ena_o` rises one cycle after them.
- R5: `mbias_ena_o` and `mref_buf_ena_o` rise together LDO_MS*CLK_KHZ+1 cycles after `ldo_ena_o` rises, with `mref_div_o` = 2'b11.
- R6: `mref_ena_o` rises one cycle after the bias step. `ldo_fref_o` and `ldo_sbias_o` fall REF_MS*CLK_KHZ+1 cycles later.
- R7: One cycle after the regulator returns to normal, `mref_fast_o` and `sbias_ena_o` fall and `mref_div_o` becomes 2'b01. `sbias_src_o` and `mref_ramp_o` keep their values.
- R8: `vbuf_gain_o` and `vbuf_qb_o` are 0 until the cycle after the reference returns to normal. From then on they follow `vbuf_gain_i` and `vbuf_qb_i` with one register of delay.
- R9: `vbuf_ena_o` rises one cycle after gain is applied, in the same cycle as `done_o`, and `busy_o` falls at that moment.
- R10: A start pulse while busy or done is ignored: the timing of a running sequence is unchanged, and `done_o` and the outputs hold.
- R11: A software reset in the middle of a sequence returns the block to idle at the next edge. The block stays idle until a new start arrives, and a new start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset |
| start_i | input | 1 | Start request, sampled in idle |
| vbuf_gain_i | input | GAIN_W | Video buffer gain setting |
| vbuf_qb_i | input | QB_W | Video buffer Q-boost setting |
| mref_fast_o | output | 1 | Reference fast-start |
| mref_ramp_o | output | 2 | Reference ramp code |
| sbias_ena_o | output | 1 | Start-up bias enable |
| sbias_src_o | output | 1 | Start-up bias source select |
| ldo_fref_o | output | 1 | Regulator fast-reference select |
| ldo_sbias_o | output | 1 | Regulator start-up bias |
| ldo_ena_o | output | 1 | Regulator enable |
| mbias_ena_o | output | 1 | Master bias enable |
| mref_buf_ena_o | output | 1 | Reference buffer enable |
| mref_div_o | output | 2 | Reference divider select |
| mref_ena_o | output | 1 | Reference enable |
| vbuf_ena_o | output | 1 | Video buffer enable |
| vbuf_gain_o | output | GAIN_W | Applied video buffer gain |
| vbuf_qb_o | output | QB_W | Applied video buffer Q-boost |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, held until reset |

## Verification
A wrong state register or a skipped step shows at the ports within one cycle, as a shifted or missing edge on one of the enable outputs. The bench therefore times every edge against the start pulse. A wrong wait-timer load or decrement shows only as a wrong gap between the regulator enable and the master bias, or between the reference enable and the regulator's return to normal, so both gaps are measured exactly in cycles. Step logic that corrupts a field only shows when that field is sampled at the edge where it should change, so the divider and ramp codes are read at those edges.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FAST,
        ST_LDO_PREP,
        ST_LDO_ON,
        ST_LDO_WAIT,
        ST_BIAS_ON,
        ST_REF_ON,
        ST_REF_WAIT,
        ST_LDO_NORM,
        ST_REF_NORM,
        ST_VB_CFG,
        ST_VB_ON,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       mref_fast;
        logic [1:0] mref_ramp;
        logic       sbias_ena;
        logic       sbias_src;
        logic       ldo_fref;
        logic       ldo_sbias;
        logic       ldo_ena;
        logic       mbias_ena;
        logic       mref_buf_ena;
        logic [1:0] mref_div;
        logic       mref_ena;
        logic       vbuf_ena;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '0;
    localparam logic [1:0] RAMP_SOFT = 2'b01;
    localparam logic [1:0] DIV_FAST  = 2'b11;
    localparam logic [1:0] DIV_NORM  = 2'b01;

endpackage

// File: rtl/bps_delay_timer.sv
module bps_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bps_step_decode.sv
module bps_step_decode
    import bps_pkg::*;
(
    input  seq_state_e state,
    input  ctl_t       cur,
    output ctl_t       nxt
);
    always_comb begin
        nxt = cur;
        unique case (state)
            ST_CLEAR:    nxt = CTL_DEFAULT;
            ST_FAST: begin
                nxt.mref_fast = 1'b1;
                nxt.sbias_ena = 1'b1;
                nxt.sbias_src = 1'b1;
                nxt.mref_ramp = RAMP_SOFT;
            end
            ST_LDO_PREP: begin
                nxt.ldo_fref  = 1'b1;
                nxt.ldo_sbias = 1'b1;
            end
            ST_LDO_ON:   nxt.ldo_ena = 1'b1;
            ST_BIAS_ON: begin
                nxt.mbias_ena    = 1'b1;
                nxt.mref_buf_ena = 1'b1;
                nxt.mref_div     = DIV_FAST;
            end
            ST_REF_ON:   nxt.mref_ena = 1'b1;
            ST_LDO_NORM: begin
                nxt.ldo_fref  = 1'b0;
                nxt.ldo_sbias = 1'b0;
            end
            ST_REF_NORM: begin
                nxt.mref_fast = 1'b0;
                nxt.sbias_ena = 1'b0;
                nxt.mref_div  = DIV_NORM;
            end
            ST_VB_ON:    nxt.vbuf_ena = 1'b1;
            ST_IDLE, ST_LDO_WAIT, ST_REF_WAIT, ST_VB_CFG, ST_DONE: nxt = cur;
            default:     nxt = CTL_DEFAULT;
        endcase
    end
endmodule

// File: rtl/bias_powerup_seq.sv
module bias_powerup_seq
    import bps_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 50000,
    parameter int unsigned LDO_MS  = 300,
    parameter int unsigned REF_MS  = 150,
    parameter int          GAIN_W  = 1,
    parameter int          QB_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              start_i,
    input  logic [GAIN_W-1:0] vbuf_gain_i,
    input  logic [QB_W-1:0]   vbuf_qb_i,
    output logic              mref_fast_o,
    output logic [1:0]        mref_ramp_o,
    output logic              sbias_ena_o,
    output logic              sbias_src_o,
    output logic              ldo_fref_o,
    output logic              ldo_sbias_o,
    output logic              ldo_ena_o,
    output logic              mbias_ena_o,
    output logic              mref_buf_ena_o,
    output logic [1:0]        mref_div_o,
    output logic              mref_ena_o,
    output logic              vbuf_ena_o,
    output logic [GAIN_W-1:0] vbuf_gain_o,
    output logic [QB_W-1:0]   vbuf_qb_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned LDO_CYC = (LDO_MS * CLK_KHZ > 0) ? LDO_MS * CLK_KHZ : 1;
    localparam int unsigned REF_CYC = (REF_MS * CLK_KHZ > 0) ? REF_MS * CLK_KHZ : 1;
    localparam int unsigned MAX_CYC = (LDO_CYC > REF_CYC) ? LDO_CYC : REF_CYC;
    localparam int          TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] LDO_LOAD = TW'(LDO_CYC - 1);
    localparam logic [TW-1:0] REF_LOAD = TW'(REF_CYC - 1);

    seq_state_e state_q, state_d;
    ctl_t       ctl_q, ctl_nxt;
    logic [GAIN_W-1:0] gain_q;
    logic [QB_W-1:0]   qb_q;
    logic       tmr_load, tmr_dec, tmr_done;
    logic       cfg_live;

    assign tmr_load = (state_q == ST_LDO_ON) || (state_q == ST_REF_ON);
    assign tmr_dec  = (state_q == ST_LDO_WAIT) || (state_q == ST_REF_WAIT);
    assign cfg_live = (state_q == ST_VB_CFG) || (state_q == ST_VB_ON) || (state_q == ST_DONE);

    bps_delay_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_rst_i),
        .load     (tmr_load),
        .load_val ((state_q == ST_LDO_ON) ? LDO_LOAD : REF_LOAD),
        .dec      (tmr_dec),
        .expired  (tmr_done)
    );

    bps_step_decode i_decode (
        .state (state_q),
        .cur   (ctl_q),
        .nxt   (ctl_nxt)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_CLEAR;
            ST_CLEAR:    state_d = ST_FAST;
            ST_FAST:     state_d = ST_LDO_PREP;
            ST_LDO_PREP: state_d = ST_LDO_ON;
            ST_LDO_ON:   state_d = ST_LDO_WAIT;
            ST_LDO_WAIT: if (tmr_done) state_d = ST_BIAS_ON;
            ST_BIAS_ON:  state_d = ST_REF_ON;
            ST_REF_ON:   state_d = ST_REF_WAIT;
            ST_REF_WAIT: if (tmr_done) state_d = ST_LDO_NORM;
            ST_LDO_NORM: state_d = ST_REF_NORM;
            ST_REF_NORM: state_d = ST_VB_CFG;
            ST_VB_CFG:   state_d = ST_VB_ON;
            ST_VB_ON:    state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (sw_rst_i)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_DEFAULT;
            gain_q <= '0;
            qb_q   <= '0;
        end else if (sw_rst_i) begin
            ctl_q  <= CTL_DEFAULT;
            gain_q <= '0;
            qb_q   <= '0;
        end else begin
            ctl_q  <= ctl_nxt;
            gain_q <= cfg_live ? vbuf_gain_i : '0;
            qb_q   <= cfg_live ? vbuf_qb_i   : '0;
        end
    end

    assign mref_fast_o    = ctl_q.mref_fast;
    assign mref_ramp_o    = ctl_q.mref_ramp;
    assign sbias_ena_o    = ctl_q.sbias_ena;
    assign sbias_src_o    = ctl_q.sbias_src;
    assign ldo_fref_o     = ctl_q.ldo_fref;
    assign ldo_sbias_o    = ctl_q.ldo_sbias;
    assign ldo_ena_o      = ctl_q.ldo_ena;
    assign mbias_ena_o    = ctl_q.mbias_ena;
    assign mref_buf_ena_o = ctl_q.mref_buf_ena;
    assign mref_div_o     = ctl_q.mref_div;
    assign mref_ena_o     = ctl_q.mref_ena;
    assign vbuf_ena_o     = ctl_q.vbuf_ena;
    assign vbuf_gain_o    = gain_q;
    assign vbuf_qb_o      = qb_q;
    assign busy_o         = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done_o         = (state_q == ST_DONE);
endmodule

// File: rtl/bps_checker.sv
module bps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst_i,
    input logic       mref_fast_o,
    input logic [1:0] mref_ramp_o,
    input logic       sbias_ena_o,
    input logic       sbias_src_o,
    input logic       ldo_fref_o,
    input logic       ldo_sbias_o,
    input logic       ldo_ena_o,
    input logic       mbias_ena_o,
    input logic       mref_buf_ena_o,
    input logic [1:0] mref_div_o,
    input logic       mref_ena_o,
    input logic       vbuf_ena_o,
    input logic       busy_o,
    input logic       done_o
);
    // R1
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> !(mref_fast_o || sbias_ena_o || sbias_src_o || ldo_fref_o ||
            ldo_sbias_o || ldo_ena_o || mbias_ena_o || mref_buf_ena_o || mref_ena_o ||
            vbuf_ena_o || (mref_ramp_o != 2'b00) || (mref_div_o != 2'b00)));

    // R3
    fast_start_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mref_fast_o) |-> (sbias_ena_o && sbias_src_o && mref_ramp_o == 2'b01));

    // R4
    ldo_prep_before_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo_ena_o) |-> (ldo_fref_o && ldo_sbias_o && $past(ldo_fref_o)));

    // R5
    bias_after_ldo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mbias_ena_o |-> ldo_ena_o);

    // R6
    ref_after_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mref_ena_o |-> (mbias_ena_o && mref_buf_ena_o));

    // R7
    ref_normal_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mref_fast_o) && !$past(sw_rst_i)) |-> (!ldo_fref_o && !ldo_sbias_o && mref_div_o == 2'b01));

    // R9
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vbuf_ena_o && !busy_o));

    // R10
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !sw_rst_i) |=> done_o);

    // R11
    sw_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (!busy_o && !done_o && !ldo_ena_o && !vbuf_ena_o));
endmodule

bind bias_powerup_seq bps_checker i_bps_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_rst_i       (sw_rst_i),
    .mref_fast_o    (mref_fast_o),
    .mref_ramp_o    (mref_ramp_o),
    .sbias_ena_o    (sbias_ena_o),
    .sbias_src_o    (sbias_src_o),
    .ldo_fref_o     (ldo_fref_o),
    .ldo_sbias_o    (ldo_sbias_o),
    .ldo_ena_o      (ldo_ena_o),
    .mbias_ena_o    (mbias_ena_o),
    .mref_buf_ena_o (mref_buf_ena_o),
    .mref_div_o     (mref_div_o),
    .mref_ena_o     (mref_ena_o),
    .vbuf_ena_o     (vbuf_ena_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
);

// File: tb/test_bias_powerup_seq.sv
module test_bias_powerup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ     = 20;
    localparam int LDO_MS  = 300;
    localparam int REF_MS  = 150;
    localparam int LDO_CYC = LDO_MS * KHZ;
    localparam int REF_CYC = REF_MS * KHZ;
    localparam int LIMIT   = LDO_CYC + REF_CYC + 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_rst = 1'b0;
    logic start = 1'b0;
    logic gain_i = 1'b0;
    logic qb_i = 1'b0;
    logic mref_fast, sbias_ena, sbias_src, ldo_fref, ldo_sbias, ldo_ena;
    logic mbias_ena, mref_buf, mref_ena, vbuf_ena, busy, done;
    logic [1:0] ramp, div;
    logic gain_o, qb_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bias_powerup_seq #(
        .CLK_KHZ(KHZ), .LDO_MS(LDO_MS), .REF_MS(REF_MS), .GAIN_W(1), .QB_W(1)
    ) i_bias_powerup_seq (
        .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst), .start_i(start),
        .vbuf_gain_i(gain_i), .vbuf_qb_i(qb_i),
        .mref_fast_o(mref_fast), .mref_ramp_o(ramp), .sbias_ena_o(sbias_ena),
        .sbias_src_o(sbias_src), .ldo_fref_o(ldo_fref), .ldo_sbias_o(ldo_sbias),
        .ldo_ena_o(ldo_ena), .mbias_ena_o(mbias_ena), .mref_buf_ena_o(mref_buf),
        .mref_div_o(div), .mref_ena_o(mref_ena), .vbuf_ena_o(vbuf_ena),
        .vbuf_gain_o(gain_o), .vbuf_qb_o(qb_o), .busy_o(busy), .done_o(done)
    );

    function automatic int all_outs();
        return int'({mref_fast, ramp, sbias_ena, sbias_src, ldo_fref, ldo_sbias, ldo_ena,
                     mbias_ena, mref_buf, div, mref_ena, vbuf_ena, gain_o, qb_o, busy, done});
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            finish_run();
        end
    end

    task automatic pulse_sw_rst();
        @(negedge clk) sw_rst = 1'b1;
        @(negedge clk) sw_rst = 1'b0;
    endtask

    // R1: defaults under hardware reset and after it
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", all_outs(), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "outputs idle after reset", all_outs(), 0);
    endtask

    // R2-R10: full sequence timing; poke_at gives a start pulse while busy
    task automatic run_seq(input int poke_at);
        int t_fast = -1, t_lpre = -1, t_ldo = -1, t_bias = -1, t_ref = -1;
        int t_lnorm = -1, t_rnorm = -1, t_gain = -1, t_vbuf = -1, t_done = -1;
        int ramp_f = 0, grp_f = 0, lsb_p = 0, buf_b = 0, div_b = 0;
        int div_n = 0, se_n = 0, src_n = 0, ramp_n = 0, gain_n = 0, qb_g = 0, busy_d = 0;
        gain_i = 1'b1;
        qb_i = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2", "busy after start", int'(busy), 1);
        for (int idx = 1; idx <= LIMIT; idx++) begin
            @(negedge clk);
            start = (idx == poke_at);
            if (t_fast < 0 && mref_fast) begin
                t_fast = idx; ramp_f = int'(ramp); grp_f = int'(sbias_ena & sbias_src);
            end
            if (t_lpre < 0 && ldo_fref) begin t_lpre = idx; lsb_p = int'(ldo_sbias); end
            if (t_ldo < 0 && ldo_ena) t_ldo = idx;
            if (t_bias < 0 && mbias_ena) begin t_bias = idx; buf_b = int'(mref_buf); div_b = int'(div); end
            if (t_ref < 0 && mref_ena) t_ref = idx;
            if (t_lpre >= 0 && t_lnorm < 0 && !ldo_fref) t_lnorm = idx;
            if (t_fast >= 0 && t_rnorm < 0 && !mref_fast) begin
                t_rnorm = idx; div_n = int'(div); se_n = int'(sbias_ena); src_n = int'(sbias_src);
                ramp_n = int'(ramp); gain_n = int'(gain_o);
            end
            if (t_gain < 0 && gain_o) begin t_gain = idx; qb_g = int'(qb_o); end
            if (t_vbuf < 0 && vbuf_ena) t_vbuf = idx;
            if (done) begin t_done = idx; busy_d = int'(busy); break; end
        end
        start = 1'b0;
        chk("R2", "first step cycle", t_fast, 2);
        chk("R3", "ramp code at fast start", ramp_f, 1);
        chk("R3", "start-up bias with fast start", grp_f, 1);
        chk("R4", "regulator prep cycle", t_lpre, t_fast + 1);
        chk("R4", "regulator start-up bias with prep", lsb_p, 1);
        chk("R4", "regulator enable cycle", t_ldo, t_lpre + 1);
        chk("R5", "master bias after regulator wait", t_bias, t_ldo + LDO_CYC + 1);
        chk("R5", "buffer with master bias", buf_b, 1);
        chk("R5", "fast divider code", div_b, 3);
        chk("R6", "reference enable cycle", t_ref, t_bias + 1);
        chk("R6", "regulator normal after reference wait", t_lnorm, t_ref + REF_CYC + 1);
        chk("R7", "reference normal cycle", t_rnorm, t_lnorm + 1);
        chk("R7", "normal divider code", div_n, 1);
        chk("R7", "start-up bias cleared", se_n, 0);
        chk("R7", "source select kept", src_n, 1);
        chk("R7", "ramp code kept", ramp_n, 1);
        chk("R8", "gain zero before config", gain_n, 0);
        chk("R8", "gain applied cycle", t_gain, t_rnorm + 1);
        chk("R8", "q-boost applied with gain", qb_g, 1);
        chk("R9", "video buffer enable cycle", t_vbuf, t_gain + 1);
        chk("R9", "done with video buffer", t_done, t_vbuf);
        chk("R9", "busy low when done", busy_d, 0);
    endtask

    // R10: start when done is ignored; R8: gain follows input after config
    task automatic test_done_hold();
        int snap = all_outs();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", "outputs hold after start in done", all_outs(), snap);
        gain_i = 1'b0;
        @(negedge clk);
        chk("R8", "gain follows input", int'(gain_o), 0);
        chk("R8", "q-boost follows input", int'(qb_o), 1);
        pulse_sw_rst();
        chk("R1", "idle after software reset from done", all_outs(), 0);
    endtask

    // R11: software reset mid-sequence
    task automatic test_sw_reset();
        gain_i = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (LDO_CYC + 10) @(negedge clk);
        chk("R11", "bias up before reset", int'(mbias_ena), 1);
        pulse_sw_rst();
        chk("R11", "outputs cleared by software reset", all_outs(), 0);
        repeat (20) @(negedge clk);
        chk("R11", "stays idle without start", all_outs(), 0);
    endtask

    initial begin
        test_reset();
        run_seq(-1);
        test_done_hold();
        run_seq(100);
        pulse_sw_rst();
        test_sw_reset();
        run_seq(LDO_CYC + 50);
        finish_run();
    end
endmodule